// File: doc/BRIEF.md
# Memory Low-Power Entry and Exit Sequencer

This block sits on the controller side of a mobile DDR memory interface. It owns the clock-enable pin and can take over the command bus. When the host logic raises a power-down request, the sequencer samples the per-bank open-row flags. It then drops clock-enable with an idle command on the bus. While the pin stays low, it reports whether the memory sleeps with all banks closed (precharge power-down) or with at least one row open (active power-down).

Leaving power-down happens when the request is withdrawn, or when the refresh logic flags that a refresh is due. Clock-enable returns high with an idle command on the bus. A programmable number of exit-delay cycles is then counted down while the bus is held idle. Only after that does the block raise its ready flag and hand the bus back to the host command stream.

An exit forced by refresh disarms the request. The block does not sleep again until the request has been seen low once. A parameter selects the idle command: a no-operation (chip select low) or a deselect (chip select high).

Top module: `lp_pd_sequencer`

## Requirements
- R1: While `rstN` is low, `cke` is 1, `memCmd` is the no-operation code 4'b0111 (bits are chip-select, row-strobe, column-strobe, write-enable, all active low), `ready` is 0 and `pdMode` is 2'b00. After a clock edge with `rstN` low, the block is idle. While it is idle, `ready` is 1 and `memCmd` equals `hostCmd`.
- R2: In the idle state, `pdReq` high with `refreshDue` low starts power-down at the next edge. At that point `cke` goes to 0, `memCmd` shows the idle command and `ready` goes to 0.
- R3: `pdMode` reads 2'b01 when all `bankOpen` bits were 0 at the edge that started power-down. It reads 2'b10 when any bit was 1. It holds that value for the whole power-down, even if `bankOpen` changes. At all other times it reads 2'b00.
- R4: While in power-down with `pdReq` high and `refreshDue` low, `cke` stays 0 and `memCmd` stays the idle command.
- R5: When `pdReq` is low at an edge in power-down, `cke` returns to 1 at that edge, with the idle command on `memCmd` and `ready` still 0.
- R6: After the edge at which `cke` returns high, the block keeps `ready` at 0 and the idle command on the bus for exactly `exitDelay`+1 cycles. It samples `exitDelay` at that edge. It then raises `ready` and passes `hostCmd` through.
- R7: `refreshDue` high at an edge in power-down forces the exit of R5 and R6, even with `pdReq` still high.
- R8: After a refresh-forced exit, the block does not enter power-down again until `pdReq` has been low at an edge and is then raised again.
- R9: A request that is held or raised during the exit wait is acted on only after the wait ends. `ready` is high for two cycles before `cke` falls again.
- R10: With `USE_DESELECT` = 0 the idle command is 4'b0111. With `USE_DESELECT` = 1 it is 4'b1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| pdReq | input | 1 | Power-down request (level) |
| bankOpen | input | NUM_BANKS | Per-bank open-row flags |
| refreshDue | input | 1 | Refresh is due; forces exit |
| exitDelay | input | CNT_W | Exit-delay cycles after clock-enable rises |
| hostCmd | input | 4 | Host command {csN, rasN, casN, weN} |
| cke | output | 1 | Clock-enable to the memory |
| memCmd | output | 4 | Command driven to the memory |
| pdMode | output | 2 | 00 none, 01 precharge power-down, 10 active power-down |
| ready | output | 1 | Normal commands may be issued |

## Verification
Several checks run on every cycle:
- the mode code is never ambiguous, and it holds steady through a power-down;
- the rising clock-enable edge always carries the idle command;
- the exit counter steps down by one, and the bus stays idle while the counter is non-zero;
- a refresh flag during power-down always leads to the exit wait;
- ready never coincides with a power-down mode.

Some properties only the bench scenarios can show, because they span a whole sequence:
- the exact length of the exit wait for a given delay;
- the disarm after a refresh-forced exit, and the re-arm that follows;
- the handling of a request raised during the wait;
- the choice of idle command between the two parameter settings.

// File: rtl/lp_pkg.sv
package lp_pkg;
  localparam int CMD_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ENTER, ST_PD_PRE, ST_PD_ACT, ST_EXIT_WAIT, ST_READY
  } lpState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic resetCmd;   // reset: drive no-operation
    logic forceIdle;  // hold the idle command on the bus
    logic ckeLow;     // drive clock-enable low
    logic loadCnt;    // load exit-delay counter
    logic decCnt;     // step exit-delay counter
  } lpStrobe_t;

  localparam logic [1:0] MODE_NONE = 2'b00;
  localparam logic [1:0] MODE_PRE  = 2'b01;
  localparam logic [1:0] MODE_ACT  = 2'b10;

  localparam logic [CMD_W-1:0] CMD_NOP   = 4'b0111;
  localparam logic [CMD_W-1:0] CMD_DESEL = 4'b1111;
endpackage

// File: rtl/lp_ctrl.sv
module lp_ctrl
  import lp_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pdReq,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic                 refreshDue,
  input  logic                 cntZero,
  output lpStrobe_t            strobe,
  output logic [1:0]           pdMode,
  output logic                 ready
);
  lpState_t stateQ, stateD;
  logic [1:0] modeQ, modeD;
  logic armedQ, armedD;
  logic inPd, inSleep, exitNow;

  assign inPd    = (stateQ == ST_PD_PRE) || (stateQ == ST_PD_ACT);
  assign inSleep = inPd || (stateQ == ST_ENTER);
  assign exitNow = inPd && (refreshDue || !pdReq);

  always_comb begin
    stateD = stateQ;
    modeD  = modeQ;
    armedD = armedQ;
    if (!pdReq) armedD = 1'b1;
    else if (exitNow && refreshDue) armedD = 1'b0;
    unique case (stateQ)
      ST_IDLE: if (pdReq && armedQ && !refreshDue) begin
        stateD = ST_ENTER;
        modeD  = (|bankOpen) ? MODE_ACT : MODE_PRE;
      end
      ST_ENTER:     stateD = (modeQ == MODE_ACT) ? ST_PD_ACT : ST_PD_PRE;
      ST_PD_PRE,
      ST_PD_ACT:    if (exitNow) stateD = ST_EXIT_WAIT;
      ST_EXIT_WAIT: if (cntZero) stateD = ST_READY;
      ST_READY:     stateD = ST_IDLE;
      default:      stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      modeQ  <= MODE_NONE;
      armedQ <= 1'b1;
    end else begin
      stateQ <= stateD;
      modeQ  <= modeD;
      armedQ <= armedD;
    end
  end

  always_comb begin
    strobe.resetCmd  = !rstN;
    strobe.forceIdle = rstN && (stateQ != ST_IDLE) && (stateQ != ST_READY);
    strobe.ckeLow    = rstN && inSleep;
    strobe.loadCnt   = rstN && exitNow;
    strobe.decCnt    = rstN && (stateQ == ST_EXIT_WAIT) && !cntZero;
  end

  assign pdMode = (rstN && inSleep) ? modeQ : MODE_NONE;
  assign ready  = rstN && ((stateQ == ST_IDLE) || (stateQ == ST_READY));

  // R3: mode code never ambiguous
  a_r3_mode_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pdMode));
  // R3: mode steady through power-down
  a_r3_mode_stable: assert property (@(posedge clk) disable iff (!rstN)
    inPd |-> $stable(pdMode));
  // R7: refresh during power-down leads to exit wait
  a_r7_refresh_exit: assert property (@(posedge clk) disable iff (!rstN)
    (inPd && refreshDue) |=> (stateQ == ST_EXIT_WAIT));
  // R6: ready and a power-down mode never together
  a_r6_ready_no_mode: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (pdMode == MODE_NONE));
endmodule

// File: rtl/lp_datapath.sv
module lp_datapath
  import lp_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter bit USE_DESELECT = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  lpStrobe_t        strobe,
  input  logic [CNT_W-1:0] exitDelay,
  input  logic [CMD_W-1:0] hostCmd,
  output logic             cke,
  output logic [CMD_W-1:0] memCmd,
  output logic             cntZero
);
  logic [CNT_W-1:0] cntQ;
  logic [CMD_W-1:0] idleCmd;

  generate
    if (USE_DESELECT) begin : g_desel
      assign idleCmd = CMD_DESEL;
    end else begin : g_nop
      assign idleCmd = CMD_NOP;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)                cntQ <= '0;
    else if (strobe.loadCnt)  cntQ <= exitDelay;
    else if (strobe.decCnt)   cntQ <= cntQ - 1'b1;
  end

  assign cntZero = (cntQ == '0);
  assign cke     = !strobe.ckeLow;

  always_comb begin
    if (strobe.resetCmd)       memCmd = CMD_NOP;
    else if (strobe.forceIdle) memCmd = idleCmd;
    else                       memCmd = hostCmd;
  end

  // R6: counter steps down by exactly one
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decCnt |=> (cntQ == $past(cntQ) - 1'b1));
  // R6: bus held idle while the delay is still counting
  a_r6_bus_held: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ != '0) |-> (memCmd == idleCmd));
  // R5: rising clock-enable carries the idle command
  a_r5_exit_edge_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |-> (memCmd == idleCmd));
endmodule

// File: rtl/lp_pd_sequencer.sv
module lp_pd_sequencer
  import lp_pkg::*;
#(
  parameter int NUM_BANKS    = 4,
  parameter int CNT_W        = 8,
  parameter bit USE_DESELECT = 1'b0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pdReq,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic                 refreshDue,
  input  logic [CNT_W-1:0]     exitDelay,
  input  logic [3:0]           hostCmd,
  output logic                 cke,
  output logic [3:0]           memCmd,
  output logic [1:0]           pdMode,
  output logic                 ready
);
  lpStrobe_t strobe;
  logic cntZero;

  lp_ctrl #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .pdReq(pdReq), .bankOpen(bankOpen),
    .refreshDue(refreshDue), .cntZero(cntZero), .strobe(strobe),
    .pdMode(pdMode), .ready(ready)
  );

  lp_datapath #(.CNT_W(CNT_W), .USE_DESELECT(USE_DESELECT)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .exitDelay(exitDelay),
    .hostCmd(hostCmd), .cke(cke), .memCmd(memCmd), .cntZero(cntZero)
  );
endmodule

// File: tb/sim_lp_pd_sequencer.sv
module sim_lp_pd_sequencer;
  logic clk = 1'b0;
  logic rstN, pdReq, refreshDue;
  logic [3:0] bankOpen;
  logic [7:0] exitDelay;
  logic [3:0] hostCmd;
  logic cke0, cke1, rdy0, rdy1;
  logic [3:0] cmd0, cmd1;
  logic [1:0] mode0, mode1;

  int nChecks = 0, nFail = 0;
  bit done = 0;

  // model state: 0 idle 1 enter 2 pd-pre 3 pd-act 4 exit-wait 5 ready
  int mSt, mMode, mCnt;
  bit mArmed;

  always #10 clk = ~clk;

  lp_pd_sequencer u0 (.clk(clk), .rstN(rstN), .pdReq(pdReq), .bankOpen(bankOpen),
    .refreshDue(refreshDue), .exitDelay(exitDelay), .hostCmd(hostCmd),
    .cke(cke0), .memCmd(cmd0), .pdMode(mode0), .ready(rdy0));

  lp_pd_sequencer #(.USE_DESELECT(1'b1)) u1 (.clk(clk), .rstN(rstN), .pdReq(pdReq),
    .bankOpen(bankOpen), .refreshDue(refreshDue), .exitDelay(exitDelay),
    .hostCmd(hostCmd), .cke(cke1), .memCmd(cmd1), .pdMode(mode1), .ready(rdy1));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] expOut(bit desel);
    logic [3:0] idleC;
    idleC = desel ? 4'b1111 : 4'b0111;
    if (!rstN) return {1'b1, 4'b0111, 1'b0, 2'b00};
    case (mSt)
      0, 5:    return {1'b1, hostCmd, 1'b1, 2'b00};
      1, 2, 3: return {1'b0, idleC, 1'b0, 2'(mMode)};
      default: return {1'b1, idleC, 1'b0, 2'b00};
    endcase
  endfunction

  task automatic tick();
    int nSt = mSt, nMode = mMode, nCnt = mCnt;
    bit nArmed = mArmed;
    string tag;
    if (!rstN) begin
      nSt = 0; nMode = 0; nCnt = 0; nArmed = 1;
    end else begin
      if (!pdReq) nArmed = 1;
      case (mSt)
        0: if (pdReq && mArmed && !refreshDue) begin
             nSt = 1; nMode = (bankOpen != 0) ? 2 : 1;
           end
        1: nSt = (mMode == 2) ? 3 : 2;
        2, 3: if (refreshDue || !pdReq) begin
             nSt = 4; nCnt = exitDelay;
             if (refreshDue && pdReq) nArmed = 0;
           end
        4: if (mCnt == 0) nSt = 5; else nCnt = mCnt - 1;
        default: nSt = 0;
      endcase
    end
    @(posedge clk);
    mSt = nSt; mMode = nMode; mCnt = nCnt; mArmed = nArmed;
    #5;
    case (mSt)
      1: tag = "R2";
      2, 3: tag = "R4";
      4: tag = "R6";
      default: tag = "R1";
    endcase
    chk({tag, " u0 outputs"}, {24'd0, cke0, cmd0, rdy0, mode0}, {24'd0, expOut(0)});
    chk({tag, "/R10 u1 outputs"}, {24'd0, cke1, cmd1, rdy1, mode1}, {24'd0, expOut(1)});
  endtask

  task automatic waitReady(output int n);
    n = 0;
    while (!rdy0 && n < 1000) begin n++; tick(); end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    int n;
    rstN = 0; pdReq = 0; refreshDue = 0; bankOpen = 0; exitDelay = 0;
    hostCmd = 4'b0011;
    mSt = 0; mMode = 0; mCnt = 0; mArmed = 1;
    #5;
    repeat (3) tick();
    chk("R1 reset cke", 32'(cke0), 1);
    chk("R1 reset cmd nop", 32'(cmd0), 32'h7);
    chk("R1 reset ready", 32'(rdy0), 0);
    rstN = 1; tick();
    chk("R1 idle ready", 32'(rdy0), 1);
    chk("R1 idle passthrough", 32'(cmd0), 32'h3);

    // precharge power-down, delay 3
    pdReq = 1; exitDelay = 8'd3; tick();
    chk("R2 cke low", 32'(cke0), 0);
    chk("R2 idle cmd", 32'(cmd0), 32'h7);
    chk("R10 deselect cmd", 32'(cmd1), 32'hF);
    tick();
    chk("R3 precharge mode", 32'(mode0), 1);
    repeat (4) tick();
    chk("R4 cke held", 32'(cke0), 0);
    pdReq = 0; tick();
    chk("R5 cke high", 32'(cke0), 1);
    chk("R5 not ready", 32'(rdy0), 0);
    waitReady(n);
    chk("R6 exit length delay 3", 32'(n), 4);
    chk("R6 passthrough after exit", 32'(cmd0), 32'h3);

    // active power-down, delay 0, banks change while asleep
    hostCmd = 4'b0101; bankOpen = 4'b0100; exitDelay = 0; pdReq = 1;
    tick(); tick();
    chk("R3 active mode", 32'(mode0), 2);
    bankOpen = 0; repeat (3) tick();
    chk("R3 mode held", 32'(mode0), 2);
    pdReq = 0; tick();
    waitReady(n);
    chk("R6 exit length delay 0", 32'(n), 1);
    tick();
    chk("R3 mode none when idle", 32'(mode0), 0);

    // refresh-forced exit and disarm
    pdReq = 1; exitDelay = 2; tick(); tick(); tick();
    refreshDue = 1; tick();
    chk("R7 refresh exit cke", 32'(cke0), 1);
    chk("R7 refresh exit not ready", 32'(rdy0), 0);
    refreshDue = 0;
    waitReady(n);
    chk("R7 exit length", 32'(n), 3);
    repeat (5) tick();
    chk("R8 no re-entry", 32'(cke0), 1);
    pdReq = 0; tick();
    pdReq = 1; tick();
    chk("R8 re-entry after rearm", 32'(cke0), 0);

    // request held through the exit wait
    tick();
    exitDelay = 5; pdReq = 0; tick();
    pdReq = 1;
    waitReady(n);
    chk("R9 wait then ready", 32'(n), 6);
    chk("R9 cke high at ready", 32'(cke0), 1);
    tick();
    chk("R9 ready second cycle", 32'(rdy0), 1);
    tick();
    chk("R9 re-entry after ready", 32'(cke0), 0);

    // reset during power-down
    tick(); tick();
    rstN = 0; #1;
    chk("R1 reset mid power-down", 32'(cke0), 1);
    tick(); rstN = 1; pdReq = 0; tick();
    chk("R1 idle after reset", 32'(rdy0), 1);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule